// File: doc/BRIEF.md
# Two-Port Synchronous RAM with Cross-Port Forwarding

This block is a two-port memory in which both ports share one clock and each port can read, write or clear its output register on every rising edge. Every port input is sampled at the edge, and results appear on the port's output register one cycle later. A write also returns its own data on the writing port's output in the following cycle.

A plain dual-port array gives stale data when one port reads an address that the other port is writing in the same edge. This block compares the two addresses at the edge and stores a source select per port. On the next cycle a small output multiplexer then takes the other port's captured write data instead of the array word. The block also raises a one-cycle flag when both ports write the same address together. In that case it resolves the stored word in favour of port A, so the array contents are always defined.

Each port's clear input empties only that port's output register and never touches the array. A port whose enable is low leaves both its output and the array alone.

Top module: `dpr_bypass_ram`

## Requirements
- R1: When a port has enable=1, clear=0 and write-enable=1 at a rising edge, its data input is stored at its address, and the same port's output equals that data input from the next cycle on.
- R2: When a port has enable=1, clear=0 and write-enable=0 at a rising edge, its output shows the word stored at its address from the next cycle on, provided the other port is not writing that address at the same edge.
- R3: When a port has enable=1 and clear=1 at a rising edge, its output becomes 0 in the next cycle, and the array keeps its contents even if write-enable is also 1.
- R4: When a port has enable=0 at a rising edge, its output keeps its previous value, and the array is not written whatever its write-enable, address and data inputs are.
- R5: When port B reads an address at the same edge at which port A writes that address, port B's output shows port A's new data in the next cycle.
- R6: When port A reads an address at the same edge at which port B writes that address, port A's output shows port B's new data in the next cycle.
- R7: When both ports write the same address at one edge, the array keeps port A's data for that address.
- R8: The collision output is 1 in the cycle that follows an edge at which both ports write the same address, and is 0 after every other edge.
- R9: After an edge with the synchronous active-high reset asserted, both port outputs are 0 and the collision output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports, rising edge |
| rst | input | 1 | Synchronous active-high reset of the output selects and the collision flag |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write enable |
| a_clr | input | 1 | Port A output-register clear |
| a_addr | input | ADDR_W | Port A address |
| a_din | input | DATA_W | Port A write data |
| a_dout | output | DATA_W | Port A read data |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write enable |
| b_clr | input | 1 | Port B output-register clear |
| b_addr | input | ADDR_W | Port B address |
| b_din | input | DATA_W | Port B write data |
| b_dout | output | DATA_W | Port B read data |
| collide | output | 1 | One-cycle flag for a same-address double write |

## Verification
The hardest case to reach is a read on one port at the same edge as a write on the other port to the same address, where the new word is different from the stale array word. The stimulus first stores a known old value at that address and then issues the write and the read together, so that a missing forwarding path shows up as the old value. It then reads the same address again on its own to confirm that the array itself was updated. A second sequence holds enable low and asserts clear while write-enable stays high. After each of those edges it reads the address back, which shows through the normal read path that the array was left unchanged.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_CLEAR = 2'd3
  } port_op_t;

  typedef enum logic [1:0] {
    SRC_ZERO  = 2'd0,
    SRC_ARRAY = 2'd1,
    SRC_OWN   = 2'd2,
    SRC_XPORT = 2'd3
  } out_src_t;

  // Clear outranks write; a disabled port does nothing.
  function automatic port_op_t decode_op(input logic en, input logic we, input logic clr);
    if (!en) return OP_IDLE;
    if (clr) return OP_CLEAR;
    if (we)  return OP_WRITE;
    return OP_READ;
  endfunction

  // Output source for the next cycle of one port.
  function automatic out_src_t pick_src(input port_op_t own_op, input port_op_t other_op,
                                        input logic same_addr);
    case (own_op)
      OP_CLEAR: return SRC_ZERO;
      OP_WRITE: return SRC_OWN;
      OP_READ:  return (other_op == OP_WRITE && same_addr) ? SRC_XPORT : SRC_ARRAY;
      default:  return SRC_ARRAY;
    endcase
  endfunction

endpackage

// File: rtl/dpr_array.sv
module dpr_array #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              a_wr,
  input  logic              a_rd,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_q,
  input  logic              b_wr,
  input  logic              b_rd,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Port A is written last so it owns a same-address double write.
  always_ff @(posedge clk) begin
    if (b_wr) mem[b_addr] <= b_wdata;
    if (a_wr) mem[a_addr] <= a_wdata;
  end

  // Read-before-write array registers; forwarding is added outside.
  always_ff @(posedge clk) begin
    if (a_rd) a_q <= mem[a_addr];
    if (b_rd) b_q <= mem[b_addr];
  end
endmodule

// File: rtl/dpr_bypass_ctl.sv
module dpr_bypass_ctl
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  port_op_t          op_a,
  input  port_op_t          op_b,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  output out_src_t          src_a_nx,
  output out_src_t          src_b_nx,
  output logic              collide
);
  logic same_addr;

  assign same_addr = (addr_a == addr_b);
  assign src_a_nx  = pick_src(op_a, op_b, same_addr);
  assign src_b_nx  = pick_src(op_b, op_a, same_addr);

  always_ff @(posedge clk) begin
    if (rst) collide <= 1'b0;
    else     collide <= (op_a == OP_WRITE) && (op_b == OP_WRITE) && same_addr;
  end
endmodule

// File: rtl/dpr_out_stage.sv
module dpr_out_stage
  import dpr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  out_src_t          src_nx,
  input  logic [DATA_W-1:0] own_wdata,
  input  logic [DATA_W-1:0] xport_wdata,
  input  logic [DATA_W-1:0] array_q,
  output logic [DATA_W-1:0] dout
);
  out_src_t          src_q;
  logic [DATA_W-1:0] own_q;
  logic [DATA_W-1:0] xport_q;

  // Every source holds while the port is idle, so the output holds too.
  always_ff @(posedge clk) begin
    if (rst)       src_q <= SRC_ZERO;
    else if (load) src_q <= src_nx;
  end

  always_ff @(posedge clk) begin
    if (load && src_nx == SRC_OWN)   own_q   <= own_wdata;
    if (load && src_nx == SRC_XPORT) xport_q <= xport_wdata;
  end

  always_comb begin
    case (src_q)
      SRC_ARRAY: dout = array_q;
      SRC_OWN:   dout = own_q;
      SRC_XPORT: dout = xport_q;
      default:   dout = '0;
    endcase
  end
endmodule

// File: rtl/dpr_bypass_ram.sv
module dpr_bypass_ram
  import dpr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_en,
  input  logic              a_we,
  input  logic              a_clr,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_din,
  output logic [DATA_W-1:0] a_dout,
  input  logic              b_en,
  input  logic              b_we,
  input  logic              b_clr,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_din,
  output logic [DATA_W-1:0] b_dout,
  output logic              collide
);
  localparam int NPORT = 2;

  port_op_t          op     [NPORT];
  out_src_t          src_nx [NPORT];
  logic [DATA_W-1:0] din    [NPORT];
  logic [DATA_W-1:0] q      [NPORT];
  logic [DATA_W-1:0] dout   [NPORT];

  assign op[0]  = decode_op(a_en, a_we, a_clr);
  assign op[1]  = decode_op(b_en, b_we, b_clr);
  assign din[0] = a_din;
  assign din[1] = b_din;
  assign a_dout = dout[0];
  assign b_dout = dout[1];

  dpr_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
    .clk     (clk),
    .a_wr    (op[0] == OP_WRITE),
    .a_rd    (op[0] == OP_READ),
    .a_addr  (a_addr),
    .a_wdata (a_din),
    .a_q     (q[0]),
    .b_wr    (op[1] == OP_WRITE),
    .b_rd    (op[1] == OP_READ),
    .b_addr  (b_addr),
    .b_wdata (b_din),
    .b_q     (q[1])
  );

  dpr_bypass_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .op_a     (op[0]),
    .op_b     (op[1]),
    .addr_a   (a_addr),
    .addr_b   (b_addr),
    .src_a_nx (src_nx[0]),
    .src_b_nx (src_nx[1]),
    .collide  (collide)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpr_out_stage #(.DATA_W(DATA_W)) u_out (
      .clk         (clk),
      .rst         (rst),
      .load        (op[p] != OP_IDLE),
      .src_nx      (src_nx[p]),
      .own_wdata   (din[p]),
      .xport_wdata (din[NPORT-1-p]),
      .array_q     (q[p]),
      .dout        (dout[p])
    );
  end
endmodule

// File: rtl/dpr_bypass_ram_chk.sv
module dpr_bypass_ram_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              a_en,
  input logic              a_we,
  input logic              a_clr,
  input logic [ADDR_W-1:0] a_addr,
  input logic [DATA_W-1:0] a_din,
  input logic [DATA_W-1:0] a_dout,
  input logic              b_en,
  input logic              b_we,
  input logic              b_clr,
  input logic [ADDR_W-1:0] b_addr,
  input logic [DATA_W-1:0] b_din,
  input logic [DATA_W-1:0] b_dout,
  input logic              collide
);
  logic a_wr, b_wr, a_rd, b_rd, dbl_wr;

  assign a_wr   = a_en && a_we && !a_clr;
  assign b_wr   = b_en && b_we && !b_clr;
  assign a_rd   = a_en && !a_we && !a_clr;
  assign b_rd   = b_en && !b_we && !b_clr;
  assign dbl_wr = a_wr && b_wr && (a_addr == b_addr);

  assert_a_readback_R1: assert property (@(posedge clk) disable iff (rst)
    a_wr |=> a_dout == $past(a_din));
  assert_b_readback_R1: assert property (@(posedge clk) disable iff (rst)
    b_wr |=> b_dout == $past(b_din));

  assert_a_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (a_en && a_clr) |=> a_dout == '0);
  assert_b_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (b_en && b_clr) |=> b_dout == '0);

  assert_a_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !a_en |=> $stable(a_dout));
  assert_b_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !b_en |=> $stable(b_dout));

  assert_b_forward_R5: assert property (@(posedge clk) disable iff (rst)
    (a_wr && b_rd && a_addr == b_addr) |=> b_dout == $past(a_din));
  assert_a_forward_R6: assert property (@(posedge clk) disable iff (rst)
    (b_wr && a_rd && a_addr == b_addr) |=> a_dout == $past(b_din));

  assert_collide_set_R8: assert property (@(posedge clk) disable iff (rst)
    dbl_wr |=> collide);
  assert_collide_cause_R8: assert property (@(posedge clk) disable iff (rst)
    collide |-> $past(dbl_wr));
endmodule

bind dpr_bypass_ram dpr_bypass_ram_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst),
  .a_en(a_en), .a_we(a_we), .a_clr(a_clr), .a_addr(a_addr), .a_din(a_din), .a_dout(a_dout),
  .b_en(b_en), .b_we(b_we), .b_clr(b_clr), .b_addr(b_addr), .b_din(b_din), .b_dout(b_dout),
  .collide(collide)
);

// File: tb/dpr_bypass_ram_tb.sv
module dpr_bypass_ram_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic          a_en, a_we, a_clr, b_en, b_we, b_clr;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_din, b_din;
  logic [DW-1:0] a_dout, b_dout;
  logic          collide;

  int total = 0;
  int bad   = 0;

  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] exp_a, exp_b;
  logic          exp_col;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpr_bypass_ram #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst),
    .a_en(a_en), .a_we(a_we), .a_clr(a_clr), .a_addr(a_addr), .a_din(a_din), .a_dout(a_dout),
    .b_en(b_en), .b_we(b_we), .b_clr(b_clr), .b_addr(b_addr), .b_din(b_din), .b_dout(b_dout),
    .collide(collide)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One edge with both ports driven; the reference model follows the requirements.
  task automatic cyc(input logic ae, input logic aw, input logic ac, input logic [AW-1:0] aa,
                     input logic [DW-1:0] ad,
                     input logic be, input logic bw, input logic bc, input logic [AW-1:0] ba,
                     input logic [DW-1:0] bd);
    logic awr, bwr;
    a_en = ae; a_we = aw; a_clr = ac; a_addr = aa; a_din = ad;
    b_en = be; b_we = bw; b_clr = bc; b_addr = ba; b_din = bd;
    awr = ae && aw && !ac;
    bwr = be && bw && !bc;
    if (ae) exp_a = ac ? '0 : aw ? ad : (bwr && ba == aa) ? bd : ref_mem[aa];
    if (be) exp_b = bc ? '0 : bw ? bd : (awr && aa == ba) ? ad : ref_mem[ba];
    exp_col = awr && bwr && (aa == ba);
    if (bwr) ref_mem[ba] = bd;
    if (awr) ref_mem[aa] = ad;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(0, 0, 0, '0, '0, 0, 0, 0, '0, '0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    idle();
    idle();
    rst = 1'b0;
    exp_a = '0; exp_b = '0;
    chk("R9 a_dout", a_dout, 0);
    chk("R9 b_dout", b_dout, 0);
    chk("R9 collide", collide, 0);
  endtask

  task automatic t_write_read();
    cyc(1, 1, 0, 6'd3, 16'hA003, 1, 1, 0, 6'd5, 16'hB005);
    chk("R1 a write readback", a_dout, exp_a);
    chk("R1 b write readback", b_dout, exp_b);
    chk("R8 no collide diff addr", collide, 0);
    cyc(1, 0, 0, 6'd5, 16'h0, 1, 0, 0, 6'd3, 16'h0);
    chk("R2 a reads b word", a_dout, 16'hB005);
    chk("R2 b reads a word", b_dout, 16'hA003);
    cyc(1, 1, 0, 6'd10, 16'h1234, 1, 0, 0, 6'd3, 16'h0);
    chk("R2 b read other addr during a write", b_dout, exp_b);
  endtask

  task automatic t_forward();
    cyc(1, 1, 0, 6'd7, 16'h0707, 0, 0, 0, '0, '0);
    cyc(1, 1, 0, 6'd7, 16'h7E7E, 1, 0, 0, 6'd7, 16'h0);
    chk("R5 b sees a new data", b_dout, 16'h7E7E);
    cyc(0, 0, 0, '0, '0, 1, 1, 0, 6'd9, 16'h0909);
    cyc(1, 0, 0, 6'd9, 16'h0, 1, 1, 0, 6'd9, 16'h9E9E);
    chk("R6 a sees b new data", a_dout, 16'h9E9E);
    cyc(1, 0, 0, 6'd7, 16'h0, 1, 0, 0, 6'd9, 16'h0);
    chk("R1 array holds a forwarded word", a_dout, 16'h7E7E);
    chk("R1 array holds b forwarded word", b_dout, 16'h9E9E);
  endtask

  task automatic t_clear();
    cyc(1, 1, 1, 6'd3, 16'hDEAD, 1, 0, 1, 6'd5, 16'h0);
    chk("R3 a cleared", a_dout, 0);
    chk("R3 b cleared", b_dout, 0);
    cyc(1, 0, 0, 6'd3, 16'h0, 0, 0, 0, '0, '0);
    chk("R3 array unchanged by clear", a_dout, 16'hA003);
    chk("R4 b idle keeps zero", b_dout, 0);
  endtask

  task automatic t_hold();
    cyc(1, 0, 0, 6'd5, 16'h0, 1, 0, 0, 6'd7, 16'h0);
    cyc(0, 1, 0, 6'd5, 16'hBAD1, 0, 1, 0, 6'd7, 16'hBAD2);
    chk("R4 a holds", a_dout, 16'hB005);
    chk("R4 b holds", b_dout, 16'h7E7E);
    cyc(0, 1, 1, 6'd5, 16'hBAD3, 0, 0, 0, '0, '0);
    chk("R4 a holds with clr while disabled", a_dout, 16'hB005);
    cyc(1, 0, 0, 6'd5, 16'h0, 1, 0, 0, 6'd7, 16'h0);
    chk("R4 a word not written", a_dout, 16'hB005);
    chk("R4 b word not written", b_dout, 16'h7E7E);
  endtask

  task automatic t_collide();
    cyc(1, 1, 0, 6'd12, 16'hAAAA, 1, 1, 0, 6'd12, 16'hBBBB);
    chk("R8 collide raised", collide, 1);
    chk("R1 a own data on collide", a_dout, 16'hAAAA);
    chk("R1 b own data on collide", b_dout, 16'hBBBB);
    idle();
    chk("R8 collide drops", collide, exp_col);
    cyc(0, 0, 0, '0, '0, 1, 0, 0, 6'd12, 16'h0);
    chk("R7 a data wins", b_dout, 16'hAAAA);
    cyc(1, 1, 0, 6'd12, 16'h1111, 1, 1, 0, 6'd13, 16'h2222);
    chk("R8 no collide different addresses", collide, 0);
    cyc(1, 0, 0, 6'd12, 16'h0, 1, 0, 0, 6'd13, 16'h0);
    chk("R2 a after split writes", a_dout, exp_a);
    chk("R2 b after split writes", b_dout, exp_b);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 'x;
    exp_a = '0; exp_b = '0; exp_col = 1'b0;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_forward();
    t_clear();
    t_hold();
    t_collide();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule